// File: doc/BRIEF.md
# Stack Bytecode Executor

This block runs a small set of one-byte stack-machine opcodes straight out of a byte-addressed program memory. It holds a 32-bit operand stack and four 32-bit local-variable registers. Each cycle it fetches one opcode byte. The inline-argument push takes a second cycle to read the byte that follows the opcode. The block then updates the stack and the locals.

A host loads a program into memory and pulses start with the entry address. The engine runs until one of three things happens: it reaches a return, it makes a stack fault, or it meets an unknown opcode. It then halts with a flag that tells which of these occurred. Debug outputs expose the top of stack, the stack depth and any selected local, so the host can read results after the halt.

The program read port is asynchronous. The read data for `pmem_addr_o` must be valid in the same cycle.

Top module: `stk_exec_top`

## Requirements
- R1: After reset, busy, done, the stack-fault flag and the illegal-opcode flag are 0, depth and top-of-stack read 0, and all four locals read 0.
- R2: A start pulse loads the program counter from `start_addr_i`, empties the stack, clears done and both fault flags, and begins fetching at that address. The program counter is always visible on `pmem_addr_o`.
- R3: Opcode 0x10 pushes the following program byte, sign-extended from 8 to 32 bits. The program counter advances by 2 over two cycles.
- R4: Opcode 0x03 pushes the value 0.
- R5: Opcodes 0x1B, 0x1C and 0x1D push local 1, 2 and 3 respectively, and leave every local unchanged.
- R6: Opcodes 0x3B, 0x3C, 0x3D and 0x3E pop the top of stack into local 0, 1, 2 and 3 respectively.
- R7: Opcode 0x60 replaces the top two entries with their sum modulo 2^32, so the depth drops by one.
- R8: Opcode 0xB1 sets done and halts with the program counter left on the return opcode. Done, the program counter, the stack and the locals then hold until the next start.
- R9: A push (0x10, 0x03, 0x1B–0x1D) with 16 entries already on the stack sets the stack-fault flag and halts. The stack is left unchanged and the program counter stays on the faulting opcode.
- R10: A store with an empty stack, or 0x60 with fewer than two entries, sets the stack-fault flag and halts. The stack and locals are left unchanged.
- R11: Any other opcode value (for example 0x1A or 0xFF) sets the illegal-opcode flag and halts with the stack unchanged. Done stays 0.
- R12: A start pulse given while the engine is halted restarts execution. It clears the flags, and the locals keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | AW (16) | Entry address loaded on start |
| pmem_addr_o | output | AW (16) | Program memory byte address (program counter) |
| pmem_rdata_i | input | 8 | Program byte at `pmem_addr_o`, same cycle |
| busy_o | output | 1 | Engine is fetching or executing |
| done_o | output | 1 | Halted on return |
| stk_err_o | output | 1 | Halted on stack overflow or underflow |
| ill_op_o | output | 1 | Halted on an unknown opcode |
| tos_o | output | DW (32) | Top of stack, 0 when empty |
| depth_o | output | $clog2(DEPTH+1) (5) | Number of stack entries |
| loc_sel_i | input | 2 | Local select for debug read |
| loc_data_o | output | DW (32) | Selected local value |

## Verification
The bench aims at the stack edges: exactly sixteen pushes must succeed, and the seventeenth must fault. A design with an off-by-one depth check would either fault one push early or wrap the stack pointer and overwrite entry 0. A push with the 0x10 opcode on a full stack must also fault before the argument is read; a design that moves to the argument cycle first would leave the program counter one byte too far. Other checks cover sign extension of the 0x80 and 0x7F arguments, addition that wraps through zero, and a store or add on a short stack. A design that misses the underflow would leave garbage in a local or a negative depth. Restarting after a fault confirms that the flags clear and the locals survive.

// File: rtl/stk_exec_pkg.sv
package stk_exec_pkg;
  localparam int NLOC = 4;
  localparam int LIW  = $clog2(NLOC);

  localparam logic [7:0] OPC_PUSH_ARG  = 8'h10;
  localparam logic [7:0] OPC_PUSH_ZERO = 8'h03;
  localparam logic [7:0] OPC_ADD       = 8'h60;
  localparam logic [7:0] OPC_RET       = 8'hB1;

  typedef enum logic [2:0] {
    K_ARG, K_ZERO, K_LOAD, K_STORE, K_ADD, K_RET, K_ILL
  } op_kind_e;

  typedef struct packed {
    op_kind_e         kind;
    logic [LIW-1:0]   idx;
  } op_dec_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_FETCH, ST_ARG, ST_HALT
  } state_e;
endpackage

// File: rtl/stk_exec_decode.sv
module stk_exec_decode
  import stk_exec_pkg::*;
(
  input  logic [7:0] opc_i,
  output op_dec_t    dec_o
);
  always_comb begin
    dec_o.kind = K_ILL;
    dec_o.idx  = '0;
    case (opc_i)
      OPC_PUSH_ARG:  dec_o.kind = K_ARG;
      OPC_PUSH_ZERO: dec_o.kind = K_ZERO;
      OPC_ADD:       dec_o.kind = K_ADD;
      OPC_RET:       dec_o.kind = K_RET;
      8'h1B: begin dec_o.kind = K_LOAD;  dec_o.idx = LIW'(1); end
      8'h1C: begin dec_o.kind = K_LOAD;  dec_o.idx = LIW'(2); end
      8'h1D: begin dec_o.kind = K_LOAD;  dec_o.idx = LIW'(3); end
      8'h3B: begin dec_o.kind = K_STORE; dec_o.idx = LIW'(0); end
      8'h3C: begin dec_o.kind = K_STORE; dec_o.idx = LIW'(1); end
      8'h3D: begin dec_o.kind = K_STORE; dec_o.idx = LIW'(2); end
      8'h3E: begin dec_o.kind = K_STORE; dec_o.idx = LIW'(3); end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_exec_stack.sv
module stk_exec_stack #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [1:0]    pop_cnt_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] count_o,
  output logic [DW-1:0] tos_o,
  output logic [DW-1:0] nos_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] base;

  assign base    = cnt_q - CW'(pop_cnt_i);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= base + CW'(push_i);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i && !clear_i && base == CW'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    tos_o = '0;
    nos_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) tos_o = mem_q[i];
      if (cnt_q == CW'(i + 2)) nos_o = mem_q[i];
    end
  end

  AST_STK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i) |-> (base < CW'(DEPTH))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> (CW'(pop_cnt_i) <= cnt_q)); // R10
endmodule

// File: rtl/stk_exec_locals.sv
module stk_exec_locals #(
  parameter int DW   = 32,
  parameter int NLOC = 4,
  localparam int IW  = $clog2(NLOC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o,
  input  logic [IW-1:0] dbg_idx_i,
  output logic [DW-1:0] dbg_data_o
);
  logic [DW-1:0] loc_q [NLOC];

  for (genvar g = 0; g < NLOC; g++) begin : g_loc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) loc_q[g] <= '0;
      else if (we_i && widx_i == IW'(g)) loc_q[g] <= wdata_i;
    end

    AST_LOC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && widx_i == IW'(g)) |=> $stable(loc_q[g])); // R5
  end

  assign rdata_o    = loc_q[ridx_i];
  assign dbg_data_o = loc_q[dbg_idx_i];
endmodule

// File: rtl/stk_exec_top.sv
module stk_exec_top
  import stk_exec_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  start_addr_i,
  output logic [AW-1:0]  pmem_addr_o,
  input  logic [7:0]     pmem_rdata_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           stk_err_o,
  output logic           ill_op_o,
  output logic [DW-1:0]  tos_o,
  output logic [CW-1:0]  depth_o,
  input  logic [LIW-1:0] loc_sel_i,
  output logic [DW-1:0]  loc_data_o
);
  state_e        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          done_q, done_d, serr_q, serr_d, ill_q, ill_d;

  op_dec_t       dec;
  logic [1:0]    pop_cnt;
  logic          push;
  logic [DW-1:0] wdata, tos, nos, loc_rd;
  logic [CW-1:0] cnt;
  logic          lwe;
  logic          full, empty;

  stk_exec_decode u_dec (.opc_i(pmem_rdata_i), .dec_o(dec));

  stk_exec_stack #(.DW(DW), .DEPTH(DEPTH)) u_stk (
    .clk_i, .rst_ni, .clear_i(start_i), .pop_cnt_i(pop_cnt), .push_i(push),
    .wdata_i(wdata), .count_o(cnt), .tos_o(tos), .nos_o(nos)
  );

  stk_exec_locals #(.DW(DW), .NLOC(NLOC)) u_loc (
    .clk_i, .rst_ni, .we_i(lwe), .widx_i(dec.idx), .wdata_i(tos),
    .ridx_i(dec.idx), .rdata_o(loc_rd), .dbg_idx_i(loc_sel_i), .dbg_data_o(loc_data_o)
  );

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    done_d  = done_q;
    serr_d  = serr_q;
    ill_d   = ill_q;
    pop_cnt = 2'd0;
    push    = 1'b0;
    wdata   = '0;
    lwe     = 1'b0;
    if (start_i) begin
      state_d = ST_FETCH;
      pc_d    = start_addr_i;
      done_d  = 1'b0;
      serr_d  = 1'b0;
      ill_d   = 1'b0;
    end else begin
      case (state_q)
        ST_FETCH: begin
          // Faults are caught here, before any state or pc change
          case (dec.kind)
            K_ARG, K_ZERO, K_LOAD: begin
              if (full) begin
                serr_d  = 1'b1;
                state_d = ST_HALT;
              end else if (dec.kind == K_ARG) begin
                state_d = ST_ARG;
                pc_d    = pc_q + AW'(1);
              end else begin
                push  = 1'b1;
                wdata = (dec.kind == K_LOAD) ? loc_rd : '0;
                pc_d  = pc_q + AW'(1);
              end
            end
            K_STORE: begin
              if (empty) begin
                serr_d  = 1'b1;
                state_d = ST_HALT;
              end else begin
                pop_cnt = 2'd1;
                lwe     = 1'b1;
                pc_d    = pc_q + AW'(1);
              end
            end
            K_ADD: begin
              if (cnt < CW'(2)) begin
                serr_d  = 1'b1;
                state_d = ST_HALT;
              end else begin
                pop_cnt = 2'd2;
                push    = 1'b1;
                wdata   = tos + nos;
                pc_d    = pc_q + AW'(1);
              end
            end
            K_RET: begin
              done_d  = 1'b1;
              state_d = ST_HALT;
            end
            default: begin
              ill_d   = 1'b1;
              state_d = ST_HALT;
            end
          endcase
        end
        ST_ARG: begin
          push    = 1'b1;
          wdata   = {{(DW-8){pmem_rdata_i[7]}}, pmem_rdata_i};
          pc_d    = pc_q + AW'(1);
          state_d = ST_FETCH;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      done_q  <= 1'b0;
      serr_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      done_q  <= done_d;
      serr_q  <= serr_d;
      ill_q   <= ill_d;
    end
  end

  assign pmem_addr_o = pc_q;
  assign busy_o      = (state_q == ST_FETCH) || (state_q == ST_ARG);
  assign done_o      = done_q;
  assign stk_err_o   = serr_q;
  assign ill_op_o    = ill_q;
  assign tos_o       = tos;
  assign depth_o     = cnt;

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pmem_addr_o == $past(start_addr_i)) && (depth_o == '0) && busy_o); // R2
  AST_ARG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && dec.kind == K_ARG && !full && !start_i)
      |=> (state_q == ST_ARG) && (pmem_addr_o == $past(pmem_addr_o) + AW'(1))); // R3
  AST_ADD_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && dec.kind == K_ADD && cnt >= CW'(2) && !start_i)
      |=> depth_o == $past(depth_o) - CW'(1)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(pmem_addr_o)); // R8
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && !start_i) |=> $stable(depth_o) && $stable(tos_o)); // R9
  AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, stk_err_o, ill_op_o})); // R11
  AST_ILL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_op_o |-> !busy_o); // R11
endmodule

// File: tb/sim_stk_exec_top.sv
module sim_stk_exec_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] pmem_addr;
  logic [7:0]  pmem_rdata;
  logic        busy, done, stk_err, ill_op;
  logic [31:0] tos, loc_data;
  logic [4:0]  depth;
  logic [1:0]  loc_sel = '0;
  logic [7:0]  pm [256];
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  assign pmem_rdata = pm[pmem_addr[7:0]];

  stk_exec_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .pmem_addr_o(pmem_addr), .pmem_rdata_i(pmem_rdata), .busy_o(busy),
    .done_o(done), .stk_err_o(stk_err), .ill_op_o(ill_op), .tos_o(tos),
    .depth_o(depth), .loc_sel_i(loc_sel), .loc_data_o(loc_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load(int base, int n, logic [255:0] bytes);
    for (int i = 0; i < n; i++) pm[base + i] = bytes[(n - 1 - i) * 8 +: 8];
  endtask

  task automatic run(int base);
    int k = 0;
    @(negedge clk);
    start_addr = 16'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && k < 2000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 2000) begin
      n_chk++; n_bad++;
      $display("FAIL R8 run at %0h never halted act=busy exp=idle", base);
    end
  endtask

  task automatic rd_loc(int i, output logic [31:0] v);
    loc_sel = 2'(i);
    #1 v = loc_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 flags", {29'd0, done, stk_err, ill_op}, 0);
    chk("R1 depth", 32'(depth), 0);
    chk("R1 tos", tos, 0);
    for (int i = 0; i < 4; i++) begin
      rd_loc(i, v);
      chk("R1 local", v, 0);
    end
  endtask

  task automatic t_sample_prog();
    logic [31:0] v;
    load(8'h00, 13, 104'h100F3C10093D033E1B1C603EB1);
    run(8'h00);
    chk("R8 done", 32'(done), 1);
    chk("R8 pc on return", 32'(pmem_addr), 32'h0C);
    chk("R7 depth", 32'(depth), 0);
    rd_loc(1, v); chk("R6 loc1", v, 15);
    rd_loc(2, v); chk("R6 loc2", v, 9);
    rd_loc(3, v); chk("R7 loc3 sum", v, 24);
    repeat (3) @(negedge clk);
    chk("R8 done held", 32'(done), 1);
    chk("R8 pc held", 32'(pmem_addr), 32'h0C);
  endtask

  task automatic t_sign_ext();
    load(8'h20, 5, 40'h1080107FB1);
    run(8'h20);
    chk("R3 positive arg", tos, 32'h7F);
    chk("R3 depth", 32'(depth), 2);
    chk("R3 pc", 32'(pmem_addr), 32'h24);
    load(8'h28, 3, 24'h1080B1);
    run(8'h28);
    chk("R3 negative arg", tos, 32'hFFFF_FF80);
    chk("R2 start addr and R3 pc+2", 32'(pmem_addr), 32'h2A);
  endtask

  task automatic t_zero();
    load(8'h30, 4, 32'h100703B1);
    run(8'h30);
    chk("R4 tos", tos, 0);
    chk("R4 depth", 32'(depth), 2);
  endtask

  task automatic t_locals();
    logic [31:0] v;
    load(8'h38, 4, 32'h1B1C1DB1);
    run(8'h38);
    chk("R5 depth", 32'(depth), 3);
    chk("R5 tos loc3", tos, 24);
    rd_loc(1, v); chk("R5 loc1 kept", v, 15);
    rd_loc(3, v); chk("R5 loc3 kept", v, 24);
    load(8'h3C, 4, 32'h10053BB1);
    run(8'h3C);
    rd_loc(0, v); chk("R6 loc0", v, 5);
    chk("R6 depth", 32'(depth), 0);
  endtask

  task automatic t_add();
    load(8'h48, 6, 48'h10FF100160B1);
    run(8'h48);
    chk("R7 wrap sum", tos, 0);
    chk("R7 depth", 32'(depth), 1);
    load(8'h50, 6, 48'h10FF10FF60B1);
    run(8'h50);
    chk("R7 neg sum", tos, 32'hFFFF_FFFE);
  endtask

  task automatic t_overflow();
    load(8'h60, 18, 144'h030303030303030303030303030303_102A03);
    run(8'h60);
    chk("R9 stk_err", 32'(stk_err), 1);
    chk("R9 done", 32'(done), 0);
    chk("R9 depth", 32'(depth), 16);
    chk("R9 tos kept", tos, 32'h2A);
    chk("R9 pc on fault", 32'(pmem_addr), 32'h71);
    repeat (3) @(negedge clk);
    chk("R9 depth held", 32'(depth), 16);
    load(8'hA0, 18, 144'h03030303030303030303030303030303_1005);
    run(8'hA0);
    chk("R9 arg push full", 32'(stk_err), 1);
    chk("R9 arg push pc", 32'(pmem_addr), 32'hB0);
    chk("R9 arg push tos", tos, 0);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    run(8'h30);
    chk("R12 err cleared", 32'(stk_err), 0);
    chk("R12 done", 32'(done), 1);
    rd_loc(0, v); chk("R12 loc0 kept", v, 5);
    rd_loc(3, v); chk("R12 loc3 kept", v, 24);
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    load(8'h80, 2, 16'h3CB1);
    run(8'h80);
    chk("R10 store empty", 32'(stk_err), 1);
    chk("R10 pc", 32'(pmem_addr), 32'h80);
    rd_loc(1, v); chk("R10 loc1 kept", v, 15);
    load(8'h84, 3, 24'h0360B1);
    run(8'h84);
    chk("R10 add short", 32'(stk_err), 1);
    chk("R10 depth kept", 32'(depth), 1);
    chk("R10 pc add", 32'(pmem_addr), 32'h85);
  endtask

  task automatic t_illegal();
    load(8'h90, 3, 24'h031AB1);
    run(8'h90);
    chk("R11 ill flag", 32'(ill_op), 1);
    chk("R11 other flags", {30'd0, done, stk_err}, 0);
    chk("R11 depth", 32'(depth), 1);
    chk("R11 pc", 32'(pmem_addr), 32'h91);
    load(8'h94, 1, 8'hFF);
    run(8'h94);
    chk("R11 ill FF", 32'(ill_op), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sample_prog();
    t_sign_ext();
    t_zero();
    t_locals();
    t_add();
    t_overflow();
    t_restart();
    t_underflow();
    t_illegal();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule